// File: doc/BRIEF.md
# Banked Monitor-Access Register Arbiter

This block resolves one system-register access to a banked control register for the performance monitors. The register has a low copy, used by the kernel level, and a high copy, used by the hypervisor level. Each request carries the five encoding fields, a read/write flag, the current exception level and write data. A set of configuration inputs describes the machine: whether the feature exists, the secure-monitor level's presence and enables, the hypervisor level's state, host mode, the three nested-virtualisation bits, fine-grained trap controls and the hypervisor monitor enable.

One cycle after a request, the block raises exactly one outcome. The outcome is one of: undefined, trap to the hypervisor level, trap to the secure-monitor level, access to the low copy, access to the high copy, or redirect to memory at a fixed offset. Traps report exception class 0x18. The block holds both 64-bit copies. Writes that are allowed land in the selected copy, and reads that are allowed return the selected copy. Performing the memory access for a redirect is left to the surrounding logic.

Top module: `sysreg_bank_arbiter`

## Requirements
- R1: The high name is op0=2'b10, op1=3'b100, CRn=4'b1001, CRm=4'b1101, op2=3'b011. The low name uses the same fields except op1=3'b000. A request matching neither name gives rsp_valid=0 and all outcome outputs 0 in the following cycle.
- R2: For either name, when cfg_feat=0 or req_el=0 (levels: 0 user, 1 kernel, 2 hypervisor, 3 monitor), the outcome is undefined.
- R3: A level-1 access to the high name traps to level 2 when cfg_nv[0]=1, and is undefined otherwise.
- R4: A level-2 access to either name with cfg_el3_present=1 and cfg_el3_mon_en=0 is undefined when cfg_undef_prio=1 or cfg_el3_undef=1. Otherwise it traps to level 3.
- R5: A level-1 access to the low name is resolved in this order, first match wins:
  - undefined, if level 3 is present, its monitor enable is 0 and cfg_undef_prio=1;
  - trap to level 2, if cfg_el2_enabled and cfg_fgt_present are set and either (level 3 is present with cfg_el3_fgt_en=0) or the direction's enable (cfg_fgt_rd_en for reads, cfg_fgt_wr_en for writes) is 0;
  - trap to level 2, if cfg_el2_enabled=1 and cfg_el2_mon_en=0;
  - the R4 level-3 rule;
  - the R6 redirect;
  - otherwise, access to the low copy.
- R6: The redirect to memory is taken when cfg_nv=3'b111 and no earlier R5 rule applies. It reports rsp_mem_offset=12'h8E8.
- R7: A level-2 access that passes R4 reaches the high copy through the high name. Through the low name it reaches the high copy when cfg_host=1 and the low copy otherwise.
- R8: A level-3 access with cfg_feat=1 always accesses the copy it names.
- R9: Each matching request gives rsp_valid=1 and exactly one outcome in the next cycle. rsp_class is 6'h18 on a trap and 0 otherwise.
- R10: Both copies reset to 0. An allowed write updates the selected copy at the clock edge that registers the response. An allowed read returns that copy on rsp_rdata, and rsp_rdata is 0 in every other case. Any other outcome leaves both copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op0 | input | 2 | Encoding op0 |
| req_op1 | input | 3 | Encoding op1 |
| req_crn | input | 4 | Encoding CRn |
| req_crm | input | 4 | Encoding CRm |
| req_op2 | input | 3 | Encoding op2 |
| req_write | input | 1 | 1 write, 0 read |
| req_el | input | 2 | Current exception level |
| req_wdata | input | 64 | Write data |
| cfg_feat | input | 1 | Feature implemented |
| cfg_el3_present | input | 1 | Level 3 implemented |
| cfg_el3_mon_en | input | 1 | Level-3 monitor enable |
| cfg_undef_prio | input | 1 | Undefined takes priority over level-3 trap |
| cfg_el3_undef | input | 1 | Level-3 undefined condition |
| cfg_el2_enabled | input | 1 | Level 2 enabled in current state |
| cfg_host | input | 1 | Level 2 running as host |
| cfg_nv | input | 3 | Nested-virtualisation bits |
| cfg_fgt_present | input | 1 | Fine-grained traps implemented |
| cfg_el3_fgt_en | input | 1 | Level-3 fine-grained enable |
| cfg_fgt_rd_en | input | 1 | Fine-grained read enable (0 traps) |
| cfg_fgt_wr_en | input | 1 | Fine-grained write enable (0 traps) |
| cfg_el2_mon_en | input | 1 | Level-2 monitor enable |
| rsp_valid | output | 1 | Response for last cycle's matching request |
| rsp_undef | output | 1 | Outcome: undefined |
| rsp_trap_el2 | output | 1 | Outcome: trap to level 2 |
| rsp_trap_el3 | output | 1 | Outcome: trap to level 3 |
| rsp_low_copy | output | 1 | Outcome: low copy accessed |
| rsp_high_copy | output | 1 | Outcome: high copy accessed |
| rsp_mem | output | 1 | Outcome: redirect to memory |
| rsp_class | output | 6 | Trap exception class |
| rsp_mem_offset | output | 12 | Redirect offset |
| rsp_rdata | output | 64 | Read data |

## Verification
Directed requests walk the level-1 low-name chain one rule at a time. Each step clears only the condition that was blocking the previous step, so the result shows the order of the rules and not only their presence. Reads and writes are tried with opposite fine-grained enables to show that the direction bit is chosen correctly. Level-2 host and non-host accesses through both names show which copy is selected. Trapped and undefined writes are followed by level-3 reads to show that the copies were left unchanged. Random encodings, levels and configuration bits then fill in the combinations, including near-miss encodings that differ from a name in one field.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam logic [1:0] ENC_OP0      = 2'b10;
  localparam logic [2:0] ENC_OP1_LOW  = 3'b000;
  localparam logic [2:0] ENC_OP1_HIGH = 3'b100;
  localparam logic [3:0] ENC_CRN      = 4'b1001;
  localparam logic [3:0] ENC_CRM      = 4'b1101;
  localparam logic [2:0] ENC_OP2      = 3'b011;
  localparam logic [5:0] TRAP_CLASS   = 6'h18;

  typedef enum logic [1:0] {NAME_NONE, NAME_LOW, NAME_HIGH} name_e;

  typedef enum logic [2:0] {
    OUT_NONE, OUT_UNDEF, OUT_TRAP2, OUT_TRAP3, OUT_LOW, OUT_HIGH, OUT_MEM
  } outcome_e;

  typedef struct packed {
    logic       feat;
    logic       el3_present;
    logic       el3_mon_en;
    logic       undef_prio;
    logic       el3_undef;
    logic       el2_enabled;
    logic       host;
    logic [2:0] nv;
    logic       fgt_present;
    logic       el3_fgt_en;
    logic       fgt_rd_en;
    logic       fgt_wr_en;
    logic       el2_mon_en;
  } cfg_t;

  // Level-3 monitor gate: true when level 3 blocks the access.
  function automatic logic el3_blocks(cfg_t c);
    return c.el3_present && !c.el3_mon_en;
  endfunction

  // Result when the level-3 gate blocks: undefined or trap to level 3.
  function automatic outcome_e el3_result(cfg_t c);
    return (c.undef_prio || c.el3_undef) ? OUT_UNDEF : OUT_TRAP3;
  endfunction

  // Fine-grained trap test for the low name, per direction.
  function automatic logic fgt_blocks(cfg_t c, logic wr);
    logic dir_en;
    dir_en = wr ? c.fgt_wr_en : c.fgt_rd_en;
    return c.el2_enabled && c.fgt_present &&
           ((c.el3_present && !c.el3_fgt_en) || !dir_en);
  endfunction
endpackage

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output name_e      name
);
  logic common_hit;

  assign common_hit = (op0 == ENC_OP0) && (crn == ENC_CRN) &&
                      (crm == ENC_CRM) && (op2 == ENC_OP2);

  always_comb begin
    name = NAME_NONE;
    if (common_hit) begin
      if (op1 == ENC_OP1_HIGH)     name = NAME_HIGH;
      else if (op1 == ENC_OP1_LOW) name = NAME_LOW;
    end
  end
endmodule

// File: rtl/sra_resolve.sv
module sra_resolve
  import sra_pkg::*;
(
  input  name_e      name,
  input  logic [1:0] el,
  input  logic       wr,
  input  cfg_t       cfg,
  output outcome_e   outcome
);
  logic     gate3;
  outcome_e gate3_res;
  logic     fgt_hit;
  logic     nv_all;

  assign gate3     = el3_blocks(cfg);
  assign gate3_res = el3_result(cfg);
  assign fgt_hit   = fgt_blocks(cfg, wr);
  assign nv_all    = (cfg.nv == 3'b111);

  outcome_e el1_low, el1_high, el2_res;

  // Level-1 access through the low name: ordered chain.
  always_comb begin
    if (gate3 && cfg.undef_prio)                 el1_low = OUT_UNDEF;
    else if (fgt_hit)                            el1_low = OUT_TRAP2;
    else if (cfg.el2_enabled && !cfg.el2_mon_en) el1_low = OUT_TRAP2;
    else if (gate3)                              el1_low = gate3_res;
    else if (nv_all)                             el1_low = OUT_MEM;
    else                                         el1_low = OUT_LOW;
  end

  assign el1_high = cfg.nv[0] ? OUT_TRAP2 : OUT_UNDEF;

  always_comb begin
    if (gate3)                  el2_res = gate3_res;
    else if (name == NAME_HIGH) el2_res = OUT_HIGH;
    else if (cfg.host)          el2_res = OUT_HIGH;
    else                        el2_res = OUT_LOW;
  end

  always_comb begin
    outcome = OUT_NONE;
    if (name != NAME_NONE) begin
      if (!cfg.feat) outcome = OUT_UNDEF;
      else begin
        unique case (el)
          2'd0: outcome = OUT_UNDEF;
          2'd1: outcome = (name == NAME_HIGH) ? el1_high : el1_low;
          2'd2: outcome = el2_res;
          default: outcome = (name == NAME_HIGH) ? OUT_HIGH : OUT_LOW;
        endcase
      end
    end
  end
endmodule

// File: rtl/sra_bank.sv
module sra_bank #(
  parameter int W = 64,
  parameter int COPIES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [COPIES-1:0]     wr_en,
  input  logic [W-1:0]          wdata,
  output logic [COPIES-1:0][W-1:0] q
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= '0;
      else if (wr_en[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/sysreg_bank_arbiter.sv
module sysreg_bank_arbiter
  import sra_pkg::*;
#(
  parameter int          W          = 64,
  parameter int          OFFSET_W   = 12,
  parameter logic [11:0] MEM_OFFSET = 12'h8E8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op0,
  input  logic [2:0]    req_op1,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [2:0]    req_op2,
  input  logic          req_write,
  input  logic [1:0]    req_el,
  input  logic [W-1:0]  req_wdata,
  input  logic          cfg_feat,
  input  logic          cfg_el3_present,
  input  logic          cfg_el3_mon_en,
  input  logic          cfg_undef_prio,
  input  logic          cfg_el3_undef,
  input  logic          cfg_el2_enabled,
  input  logic          cfg_host,
  input  logic [2:0]    cfg_nv,
  input  logic          cfg_fgt_present,
  input  logic          cfg_el3_fgt_en,
  input  logic          cfg_fgt_rd_en,
  input  logic          cfg_fgt_wr_en,
  input  logic          cfg_el2_mon_en,
  output logic          rsp_valid,
  output logic          rsp_undef,
  output logic          rsp_trap_el2,
  output logic          rsp_trap_el3,
  output logic          rsp_low_copy,
  output logic          rsp_high_copy,
  output logic          rsp_mem,
  output logic [5:0]    rsp_class,
  output logic [OFFSET_W-1:0] rsp_mem_offset,
  output logic [W-1:0]  rsp_rdata
);
  localparam int LOW_IDX  = 0;
  localparam int HIGH_IDX = 1;

  cfg_t     cfg;
  name_e    name;
  outcome_e outcome;
  logic     name_hit;
  logic     commit_low, commit_high;
  logic [1:0]        bank_we;
  logic [1:0][W-1:0] bank_q;
  logic [W-1:0]      copy_low, copy_high;
  logic [W-1:0]      rdata_nxt;

  assign cfg = '{feat: cfg_feat, el3_present: cfg_el3_present,
                 el3_mon_en: cfg_el3_mon_en, undef_prio: cfg_undef_prio,
                 el3_undef: cfg_el3_undef, el2_enabled: cfg_el2_enabled,
                 host: cfg_host, nv: cfg_nv, fgt_present: cfg_fgt_present,
                 el3_fgt_en: cfg_el3_fgt_en, fgt_rd_en: cfg_fgt_rd_en,
                 fgt_wr_en: cfg_fgt_wr_en, el2_mon_en: cfg_el2_mon_en};

  sra_decode u_dec (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm),
    .op2(req_op2), .name(name)
  );

  sra_resolve u_res (
    .name(name), .el(req_el), .wr(req_write), .cfg(cfg), .outcome(outcome)
  );

  assign name_hit    = req_valid && (name != NAME_NONE);
  assign commit_low  = name_hit && req_write && (outcome == OUT_LOW);
  assign commit_high = name_hit && req_write && (outcome == OUT_HIGH);
  assign bank_we     = {commit_high, commit_low};

  sra_bank #(.W(W), .COPIES(2)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .wdata(req_wdata), .q(bank_q)
  );

  assign copy_low  = bank_q[LOW_IDX];
  assign copy_high = bank_q[HIGH_IDX];

  always_comb begin
    rdata_nxt = '0;
    if (name_hit && !req_write) begin
      if (outcome == OUT_LOW)  rdata_nxt = copy_low;
      if (outcome == OUT_HIGH) rdata_nxt = copy_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_undef      <= 1'b0;
      rsp_trap_el2   <= 1'b0;
      rsp_trap_el3   <= 1'b0;
      rsp_low_copy   <= 1'b0;
      rsp_high_copy  <= 1'b0;
      rsp_mem        <= 1'b0;
      rsp_class      <= '0;
      rsp_mem_offset <= '0;
      rsp_rdata      <= '0;
    end else begin
      rsp_valid      <= name_hit;
      rsp_undef      <= name_hit && (outcome == OUT_UNDEF);
      rsp_trap_el2   <= name_hit && (outcome == OUT_TRAP2);
      rsp_trap_el3   <= name_hit && (outcome == OUT_TRAP3);
      rsp_low_copy   <= name_hit && (outcome == OUT_LOW);
      rsp_high_copy  <= name_hit && (outcome == OUT_HIGH);
      rsp_mem        <= name_hit && (outcome == OUT_MEM);
      rsp_class      <= (name_hit && (outcome == OUT_TRAP2 || outcome == OUT_TRAP3))
                        ? TRAP_CLASS : 6'h00;
      rsp_mem_offset <= (name_hit && outcome == OUT_MEM) ? MEM_OFFSET : '0;
      rsp_rdata      <= rdata_nxt;
    end
  end
endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int          W          = 64,
  parameter logic [11:0] MEM_OFFSET = 12'h8E8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         name_hit,
  input logic [1:0]   req_el,
  input logic         cfg_feat,
  input logic         rsp_valid,
  input logic         rsp_undef,
  input logic         rsp_trap_el2,
  input logic         rsp_trap_el3,
  input logic         rsp_low_copy,
  input logic         rsp_high_copy,
  input logic         rsp_mem,
  input logic [5:0]   rsp_class,
  input logic [11:0]  rsp_mem_offset,
  input logic [W-1:0] copy_low,
  input logic [W-1:0] copy_high,
  input logic         commit_low,
  input logic         commit_high
);
  logic [5:0] flags;
  assign flags = {rsp_undef, rsp_trap_el2, rsp_trap_el3,
                  rsp_low_copy, rsp_high_copy, rsp_mem};

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(flags) == 1); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> flags == 6'b0); // R1
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_trap_el2 || rsp_trap_el3) |-> rsp_class == 6'h18); // R9
  AST_MEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem |-> rsp_mem_offset == MEM_OFFSET); // R6
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (name_hit && (req_el == 2'd0 || !cfg_feat)) |=> rsp_undef); // R2
  AST_EL3_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (name_hit && req_el == 2'd3 && cfg_feat) |=> (rsp_low_copy || rsp_high_copy)); // R8
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_low |=> $stable(copy_low)); // R10
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_high |=> $stable(copy_high)); // R10
endmodule

bind sysreg_bank_arbiter sra_checker #(.W(W), .MEM_OFFSET(MEM_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .name_hit(name_hit), .req_el(req_el),
  .cfg_feat(cfg_feat), .rsp_valid(rsp_valid), .rsp_undef(rsp_undef),
  .rsp_trap_el2(rsp_trap_el2), .rsp_trap_el3(rsp_trap_el3),
  .rsp_low_copy(rsp_low_copy), .rsp_high_copy(rsp_high_copy),
  .rsp_mem(rsp_mem), .rsp_class(rsp_class), .rsp_mem_offset(rsp_mem_offset),
  .copy_low(copy_low), .copy_high(copy_high),
  .commit_low(commit_low), .commit_high(commit_high)
);

// File: tb/sysreg_bank_arbiter_test.sv
`timescale 1ns/1ps
module sysreg_bank_arbiter_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_op0 = 0, req_el = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0, cfg_nv = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic cfg_feat = 0, cfg_el3_present = 0, cfg_el3_mon_en = 0, cfg_undef_prio = 0;
  logic cfg_el3_undef = 0, cfg_el2_enabled = 0, cfg_host = 0, cfg_fgt_present = 0;
  logic cfg_el3_fgt_en = 0, cfg_fgt_rd_en = 0, cfg_fgt_wr_en = 0, cfg_el2_mon_en = 0;
  logic rsp_valid, rsp_undef, rsp_trap_el2, rsp_trap_el3, rsp_low_copy, rsp_high_copy, rsp_mem;
  logic [5:0]  rsp_class;
  logic [11:0] rsp_mem_offset;
  logic [63:0] rsp_rdata;

  sysreg_bank_arbiter uut (.*);

  int checks = 0, fails = 0;
  logic [63:0] m_low = 0, m_high = 0;
  // Expected response of the request in flight.
  int e_code = 0; logic [63:0] e_rdata = 0; string e_tag = "R9";

  // cfg vector order: feat,el3p,mon,prio,ucond,el2en,host,nv[2:0],fgtp,el3fgt,rd,wr,el2mon
  function automatic int model(int nm, int el, bit wr, logic [14:0] c, output string tag);
    bit blk3 = c[13] && !c[12];
    int res3 = (c[11] || c[10]) ? 1 : 3;
    bit dir  = wr ? c[1] : c[2];
    tag = "R9";
    if (nm == 0) begin tag = "R1"; return 0; end
    if (!c[14] || el == 0) begin tag = "R2"; return 1; end
    case (el)
      3: begin tag = "R8"; return (nm == 1) ? 4 : 5; end
      2: begin
        if (blk3) begin tag = "R4"; return res3; end
        tag = "R7";
        return (nm == 2 || c[8]) ? 5 : 4;
      end
      default: begin
        if (nm == 2) begin tag = "R3"; return c[5] ? 2 : 1; end
        tag = "R5";
        if (blk3 && c[11]) return 1;
        if (c[9] && c[4] && ((c[13] && !c[3]) || !dir)) return 2;
        if (c[9] && !c[0]) return 2;
        if (blk3) return res3;
        if (c[7:5] == 3'b111) begin tag = "R6"; return 6; end
        return 4;
      end
    endcase
  endfunction

  task automatic check_rsp();
    int code;
    int n = rsp_undef + rsp_trap_el2 + rsp_trap_el3 + rsp_low_copy + rsp_high_copy + rsp_mem;
    code = !rsp_valid ? (n == 0 ? 0 : 7) : n != 1 ? 7 :
           rsp_undef ? 1 : rsp_trap_el2 ? 2 : rsp_trap_el3 ? 3 :
           rsp_low_copy ? 4 : rsp_high_copy ? 5 : 6;
    checks++;
    if (code != e_code) begin
      fails++; $display("FAIL %s outcome actual %0d expected %0d", e_tag, code, e_code);
    end
    checks++;
    if (rsp_class != ((e_code == 2 || e_code == 3) ? 6'h18 : 6'h00)) begin
      fails++; $display("FAIL R9 class actual %h expected %h", rsp_class,
                        (e_code == 2 || e_code == 3) ? 6'h18 : 6'h00);
    end
    checks++;
    if (rsp_mem_offset != (e_code == 6 ? 12'h8E8 : 12'h000)) begin
      fails++; $display("FAIL R6 offset actual %h expected %h", rsp_mem_offset,
                        e_code == 6 ? 12'h8E8 : 12'h000);
    end
    checks++;
    if (rsp_rdata !== e_rdata) begin
      fails++; $display("FAIL R10 rdata actual %h expected %h", rsp_rdata, e_rdata);
    end
  endtask

  // One request: check the previous response, then drive this one.
  task automatic issue(int nm, int el, bit wr, logic [14:0] c, logic [63:0] d,
                       logic [15:0] raw = 16'h0);
    logic [15:0] f;
    int enc;
    string t;
    @(negedge clk);
    check_rsp();
    f = (nm == 1) ? {2'b10, 3'b000, 4'b1001, 4'b1101, 3'b011} :
        (nm == 2) ? {2'b10, 3'b100, 4'b1001, 4'b1101, 3'b011} : raw;
    {req_op0, req_op1, req_crn, req_crm, req_op2} = f;
    enc = (f[15:14] == 2'b10 && f[10:7] == 4'b1001 && f[6:3] == 4'b1101 && f[2:0] == 3'b011)
          ? (f[13:11] == 3'b000 ? 1 : f[13:11] == 3'b100 ? 2 : 0) : 0;
    req_valid = 1; req_el = el[1:0]; req_write = wr; req_wdata = d;
    {cfg_feat, cfg_el3_present, cfg_el3_mon_en, cfg_undef_prio, cfg_el3_undef,
     cfg_el2_enabled, cfg_host, cfg_nv, cfg_fgt_present, cfg_el3_fgt_en,
     cfg_fgt_rd_en, cfg_fgt_wr_en, cfg_el2_mon_en} = c;
    e_code = model(enc, el, wr, c, t);
    e_tag = t;
    e_rdata = 0;
    if (!wr && e_code == 4) e_rdata = m_low;
    if (!wr && e_code == 5) e_rdata = m_high;
    if (wr && e_code == 4) m_low = d;
    if (wr && e_code == 5) m_high = d;
  endtask

  localparam logic [14:0] OPEN = 15'b1_1_1_0_0_1_0_000_1_1_1_1_1;

  initial begin
    #3000000;
    fails++;
    $display("FAIL R9 watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // Reset state: both copies read 0 (R10).
    issue(1, 3, 0, OPEN, 0);
    issue(2, 3, 0, OPEN, 0);
    issue(2, 3, 1, OPEN, 64'hA5A5_0000_1234_5678);  // R8
    issue(1, 3, 1, OPEN, 64'h0F0F_F0F0_5555_AAAA);  // R8
    issue(2, 3, 0, OPEN, 0);
    issue(1, 3, 0, OPEN, 0);
    issue(0, 1, 0, OPEN, 0, 16'h1234);              // R1 no match
    issue(0, 2, 1, OPEN, 7, {2'b10, 3'b010, 4'b1001, 4'b1101, 3'b011}); // R1 near miss
    issue(1, 0, 1, OPEN, 9);                        // R2 level 0
    issue(2, 2, 1, OPEN & ~15'h4000, 9);            // R2 no feature
    issue(2, 1, 1, OPEN | 15'h0020, 9);             // R3 trap
    issue(2, 1, 1, OPEN, 9);                        // R3 undef, write ignored
    issue(2, 3, 0, OPEN, 0);                        // R10 unchanged
    // R5 chain peeled one rule at a time, all with nv=111 (R6 at the end).
    issue(1, 1, 1, 15'b1_1_0_1_0_1_0_111_1_0_0_0_0, 1);
    issue(1, 1, 1, 15'b1_1_0_0_0_1_0_111_1_0_0_0_0, 2);
    issue(1, 1, 1, 15'b1_1_0_0_0_1_0_111_1_1_1_0_0, 3); // write enable 0
    issue(1, 1, 0, 15'b1_1_0_0_0_1_0_111_1_1_1_0_0, 0); // read passes fgt, mon trap
    issue(1, 1, 0, 15'b1_1_0_0_0_1_0_111_1_1_1_0_1, 0); // trap3
    issue(1, 1, 0, 15'b1_1_0_0_1_1_0_111_1_1_1_0_1, 0); // undef cond
    issue(1, 1, 0, 15'b1_1_1_0_0_1_0_111_1_1_1_0_1, 0); // R6 memory
    issue(1, 1, 1, 15'b1_1_1_0_0_1_0_011_1_1_1_1_1, 64'h77); // low write
    issue(1, 3, 0, OPEN, 0);
    // R4 and R7 at level 2.
    issue(1, 2, 1, 15'b1_1_0_0_0_1_0_000_0_0_0_0_1, 5);
    issue(2, 2, 1, 15'b1_1_0_1_0_1_0_000_0_0_0_0_1, 5);
    issue(1, 2, 1, OPEN | 15'h0100, 64'hBEEF);      // host -> high
    issue(2, 2, 0, OPEN, 0);
    issue(1, 2, 0, OPEN, 0);                        // non-host -> low
    for (int i = 0; i < 4000; i++) begin
      int nm = $urandom_range(0, 9);
      logic [14:0] c = 15'($urandom);
      logic [15:0] raw = 16'($urandom);
      if ($urandom_range(0, 3) != 0) c[14] = 1;
      if (nm >= 3 && nm <= 5) raw = {2'b10, 3'($urandom), 4'b1001, 4'b1101, 3'b011};
      issue(nm > 2 ? 0 : nm == 0 ? 1 : nm, $urandom_range(0, 3), 1'($urandom), c,
            {$urandom, $urandom}, raw);
    end
    @(negedge clk);
    check_rsp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule